// File: doc/BRIEF.md
# Phase-Frequency Detector With Polarity Select

This block sits between the reference divider and the feedback divider of a frequency synthesizer. It takes one event pulse from each divider per comparison period and turns the time between them into a pump-up or pump-down pulse. These two digital pulses drive a charge pump. Both pulses cannot stay active at the same time: once both are set, they are cleared together. They are held together for one system clock first, so that a locked loop still shows a pulse of minimum width on each output in every comparison cycle.

A polarity input chooses which way the outputs act, to suit oscillators whose frequency either rises or falls with tuning voltage. In reversed polarity the up and down outputs are exchanged. The same input also picks which divider event appears on a monitor output. A lock indicator stays high while the pump pulses are no wider than a set tolerance, and drops for every cycle in which a pulse runs past it. Near lock this shows up as narrow low pulses. All inputs are one-cycle pulses sampled in the fast system clock domain, and all outputs are registered.

Top module: `pfd_polarity_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pump_up`, `pump_dn` and `monitor_o` are low and `lock_o` is high. The registered polarity comes out of reset in the normal sense (as if `pol_sel` were 1), which models an input pulled high when it is not driven.
- R2: With `pol_sel`=1, a `ref_evt` pulse sampled at clock edge k sets `pump_up` at edge k+2. `pump_up` then stays high until a `fb_evt` is also registered, and likewise `fb_evt` sets `pump_dn`.
- R3: When both internal detector flops are set, both pump outputs stay high together for exactly one clock and are then cleared. Coincident `ref_evt` and `fb_evt` pulses therefore give a one-cycle pulse on both outputs.
- R4: An event sampled during the clearing cycle is not lost. It starts a new pulse on the cycle right after the clear.
- R5: Further `ref_evt` pulses while the up side is already active do not add anything. The detector saturates, and the pulse ends only at the next `fb_evt` (and the same holds the other way round). This gives a detection range of one full period either way.
- R6: With `pol_sel`=0, sampled one edge before the output register, `pump_up` carries what `pump_dn` would carry in normal polarity, and the reverse.
- R7: `monitor_o` shows the sampled `ref_evt` when `pol_sel` was 1 and the sampled `fb_evt` when it was 0, one edge after the input register.
- R8: `lock_o` is low in each cycle in which a pump output has been continuously active for more than `LOCK_TOL` cycles (default 1). It is high in every other cycle.
- R9: With coincident events only (locked loop), `lock_o` stays high the whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_evt | input | 1 | One-cycle event from the reference divider |
| fb_evt | input | 1 | One-cycle event from the feedback divider |
| pol_sel | input | 1 | 1 = normal sense, 0 = up and down exchanged |
| pump_up | output | 1 | Registered pump-up drive |
| pump_dn | output | 1 | Registered pump-down drive |
| monitor_o | output | 1 | Selected divider event for observation |
| lock_o | output | 1 | High when in lock, narrow low pulses near lock |

## Verification
The hardest case to reach is an event that lands in the very cycle in which both detector flops are being cleared. To hit it, the bench drives `ref_evt`, then `fb_evt` one clock later, then `ref_evt` again one clock after that. The third event then reaches the detector exactly at the clear. A behavioural reference model, built from delay queues and integer counters, is compared with all four outputs on every clock. This covers that case and also the polarity changes made while pulses are still in flight.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  function automatic pump_t orient(pump_t p, logic normal);
    pump_t o;
    o.up = normal ? p.up : p.dn;
    o.dn = normal ? p.dn : p.up;
    return o;
  endfunction
endpackage

// File: rtl/pfd_insample.sv
module pfd_insample (
  input  logic clk,
  input  logic rst,
  input  logic ref_evt,
  input  logic fb_evt,
  input  logic pol_sel,
  output logic ref_q,
  output logic fb_q,
  output logic pol_q
);
  // polarity register resets to normal sense (pulled-high input)
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      pol_q <= 1'b1;
    end else begin
      ref_q <= ref_evt;
      fb_q  <= fb_evt;
      pol_q <= pol_sel;
    end
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ref_q,
  input  logic  fb_q,
  output pump_t st
);
  logic both;
  assign both = st.up & st.dn;

  // both set: hold for this cycle, clear at next edge, but let new events in
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (both) begin
      st.up <= ref_q;
      st.dn <= fb_q;
    end else begin
      st.up <= st.up | ref_q;
      st.dn <= st.dn | fb_q;
    end
  end
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic lock_o
);
  localparam int CNT_W = $clog2(LOCK_TOL + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_TOL + 1);
  localparam logic [CNT_W-1:0] TOL_V   = CNT_W'(LOCK_TOL);

  logic [CNT_W-1:0] run_cnt, run_nx;

  always_comb begin
    if (!active)                run_nx = '0;
    else if (run_cnt == CNT_MAX) run_nx = CNT_MAX;
    else                        run_nx = run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lock_o  <= 1'b1;
    end else begin
      run_cnt <= run_nx;
      lock_o  <= (run_nx <= TOL_V);
    end
  end
endmodule

// File: rtl/pfd_outstage.sv
module pfd_outstage
  import pfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pol_q,
  input  logic  ref_q,
  input  logic  fb_q,
  input  pump_t st,
  output logic  pump_up,
  output logic  pump_dn,
  output logic  monitor_o
);
  pump_t drv;
  assign drv = orient(st, pol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up   <= 1'b0;
      pump_dn   <= 1'b0;
      monitor_o <= 1'b0;
    end else begin
      pump_up   <= drv.up;
      pump_dn   <= drv.dn;
      monitor_o <= pol_q ? ref_q : fb_q;
    end
  end
endmodule

// File: rtl/pfd_polarity_top.sv
module pfd_polarity_top
  import pfd_pkg::*;
#(
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_evt,
  input  logic fb_evt,
  input  logic pol_sel,
  output logic pump_up,
  output logic pump_dn,
  output logic monitor_o,
  output logic lock_o
);
  logic  ref_q, fb_q, pol_q;
  pump_t det_st;

  pfd_insample u_in (
    .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt), .pol_sel(pol_sel),
    .ref_q(ref_q), .fb_q(fb_q), .pol_q(pol_q)
  );

  pfd_core u_core (
    .clk(clk), .rst(rst), .ref_q(ref_q), .fb_q(fb_q), .st(det_st)
  );

  pfd_outstage u_out (
    .clk(clk), .rst(rst), .pol_q(pol_q), .ref_q(ref_q), .fb_q(fb_q), .st(det_st),
    .pump_up(pump_up), .pump_dn(pump_dn), .monitor_o(monitor_o)
  );

  pfd_lock #(.LOCK_TOL(LOCK_TOL)) u_lock (
    .clk(clk), .rst(rst), .active(det_st.up | det_st.dn), .lock_o(lock_o)
  );
endmodule

// File: rtl/pfd_polarity_chk.sv
module pfd_polarity_chk (
  input logic clk,
  input logic rst,
  input logic ref_evt,
  input logic fb_evt,
  input logic pol_sel,
  input logic pump_up,
  input logic pump_dn,
  input logic monitor_o,
  input logic lock_o,
  input logic st_up,
  input logic st_dn
);
  // R3: both flops set clears next cycle unless two new events arrived together
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (st_up && st_dn) |=> (!(st_up && st_dn) || ($past(ref_evt, 2) && $past(fb_evt, 2))));

  // R5: one-sided activity is held until the other side arrives
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st_up && !st_dn) |=> st_up);

  // R6: pump_up follows the flop selected by the sampled polarity
  p_swap_r6: assert property (@(posedge clk) disable iff (rst)
    pump_up |-> ($past(pol_sel, 2) ? $past(st_up) : $past(st_dn)));

  // R7: monitor high only for the selected divider event
  p_mon_r7: assert property (@(posedge clk) disable iff (rst)
    monitor_o |-> (($past(ref_evt, 2) && $past(pol_sel, 2)) ||
                   ($past(fb_evt, 2) && !$past(pol_sel, 2))));

  // R8: no pump activity means lock indicated
  p_lock_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!pump_up && !pump_dn) |-> lock_o);
endmodule

bind pfd_polarity_top pfd_polarity_chk u_chk (
  .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt), .pol_sel(pol_sel),
  .pump_up(pump_up), .pump_dn(pump_dn), .monitor_o(monitor_o), .lock_o(lock_o),
  .st_up(det_st.up), .st_dn(det_st.dn)
);

// File: tb/tb_pfd_polarity_top.sv
`timescale 1ns/1ps
module tb_pfd_polarity_top;
  localparam int TOL = 1;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_evt = 1'b0, fb_evt = 1'b0, pol_sel = 1'b1;
  logic pump_up, pump_dn, monitor_o, lock_o;

  int checks = 0, failures = 0;
  bit started = 0, finished = 0;

  // reference model state
  bit q_ref[$], q_fb[$], q_pol[$];
  bit m_up = 0, m_dn = 0;
  int run = 0;
  bit e_up = 0, e_dn = 0, e_mon = 0, e_lock = 1;

  pfd_polarity_top #(.LOCK_TOL(TOL)) dut (
    .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt), .pol_sel(pol_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .monitor_o(monitor_o), .lock_o(lock_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      q_ref = {0}; q_fb = {0}; q_pol = {1};
      m_up = 0; m_dn = 0; run = 0;
      e_up = 0; e_dn = 0; e_mon = 0; e_lock = 1;
    end else begin
      bit r1, f1, p1;
      r1 = q_ref.pop_front(); f1 = q_fb.pop_front(); p1 = q_pol.pop_front();
      e_up  = p1 ? m_up : m_dn;
      e_dn  = p1 ? m_dn : m_up;
      e_mon = p1 ? r1 : f1;
      run   = (m_up || m_dn) ? run + 1 : 0;
      e_lock = (run <= TOL);
      if (m_up && m_dn) begin m_up = r1; m_dn = f1; end
      else begin m_up = m_up | r1; m_dn = m_dn | f1; end
      q_ref.push_back(ref_evt); q_fb.push_back(fb_evt); q_pol.push_back(pol_sel);
    end
    started = 1;
  end

  task automatic chk(string req, string nm, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R2,R3,R4,R5,R6", "pump_up", pump_up, e_up);
      chk("R2,R3,R4,R5,R6", "pump_dn", pump_dn, e_dn);
      chk("R7", "monitor_o", monitor_o, e_mon);
      chk("R8,R9", "lock_o", lock_o, e_lock);
    end
  end

  task automatic cyc(bit r, bit f);
    ref_evt = r; fb_evt = f;
    @(negedge clk);
    ref_evt = 0; fb_evt = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "pump_up", pump_up, 0);
    chk("R1", "pump_dn", pump_dn, 0);
    chk("R1", "monitor_o", monitor_o, 0);
    chk("R1", "lock_o", lock_o, 1);
    rst = 0;
    idle(2);
    // R9: locked, coincident events
    for (int k = 0; k < 6; k++) begin cyc(1, 1); idle(5); end
    // R2, R8: reference leads by four clocks
    for (int k = 0; k < 3; k++) begin cyc(1, 0); idle(3); cyc(0, 1); idle(6); end
    // R2: reference leads by one clock (narrow low on lock)
    cyc(1, 0); cyc(0, 1); idle(6);
    // R5: two reference events before feedback
    cyc(1, 0); idle(2); cyc(1, 0); idle(2); cyc(0, 1); idle(6);
    // R4: event arriving in the clear cycle
    cyc(1, 0); cyc(0, 1); cyc(1, 0); idle(3); cyc(0, 1); idle(6);
    cyc(1, 1); cyc(1, 1); cyc(1, 1); idle(6);
    // R6, R7: reversed polarity
    pol_sel = 0; idle(2);
    for (int k = 0; k < 3; k++) begin cyc(0, 1); idle(2); cyc(1, 0); idle(5); end
    cyc(1, 1); idle(5);
    // R6: polarity flips while a pulse is in flight
    cyc(1, 0); pol_sel = 1; idle(2); pol_sel = 0; idle(1); cyc(0, 1); idle(6);
    pol_sel = 1; idle(3);
    // R1: reset mid-pulse, then check the cycle right after release
    cyc(1, 0); idle(1);
    rst = 1; idle(2); rst = 0; @(negedge clk);
    chk("R1", "pump_up_after", pump_up, 0);
    chk("R1", "lock_after", lock_o, 1);
    idle(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule